// File: doc/BRIEF.md
# Wide-Beat Packet Unpacker

This block sits behind a 128-bit receive path whose beats are cut into four 32-bit lanes. Each lane holds a packet header, a payload word or an idle fill word. Packet boundaries fall on any lane. One beat may end a packet, carry idle fill, and then start the next packet. The unpacker turns this stream into a plain 32-bit word stream. Each packet leaves as its header word marked start-of-packet, followed by its payload words. The last payload word is marked end-of-packet.

An upstream framer marks each beat that carries a header with a start flag. With that flag it gives the lane number of the header and the packet length. The length is encoded as payload bytes minus one, so the 8-bit field covers 1 to 256 bytes. The unpacker counts payload words across beat boundaries and discards lanes that lie outside any packet. It raises two sticky flags. One is for a header that arrives before the previous packet is complete. The other is for a non-idle word found outside a packet. The lanes of a beat are drained one per cycle, so beat-side ready stays low while a beat is being worked through.

Top module: `beat_unpacker`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and both error flags are 0.
- R2: Lanes are handled in order, starting at lane 0 (data bits 31:0) and rising to lane 3 (bits 127:96). Each lane takes at least one cycle. After a beat is accepted, `in_ready` stays 0 until every lane of that beat has been emitted or dropped. With `out_ready` held at 1 and a beat of header, two payload words and one idle lane, `in_ready` is 0 for exactly four cycles after the accept.
- R3: A packet leaves as its header word with `out_sop`=1 and `out_eop`=0. The header is followed by exactly floor(`in_len`/4)+1 payload words. Only the last of these has `out_eop`=1. `in_len`=0 gives one payload word and `in_len`=255 gives sixty-four.
- R4: A lane that lies outside any open packet and is not the header lane is dropped and never appears on the output. If such a lane differs from the idle pattern (default 32'hC0DE_1D1E), `err_stray` is set.
- R5: A packet's payload continues across beat boundaries. While the packet is open, every lane is forwarded as payload whatever its value, including the idle pattern. In beats without `in_start`, this never sets `err_stray`.
- R6: When a beat has `in_start`=1, the header sits in lane `in_hdr_lane`. Lanes below it complete the previous packet if one is open and are dropped otherwise. Lanes above it belong to the new packet until its count runs out, and are dropped after that.
- R7: If the header lane is reached while the previous packet is still open, the block first emits one closing word. This word carries the idle pattern with `out_eop`=1 and `out_sop`=0. The new header follows it with `out_sop`=1, and `err_trunc` is set.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_sop` and `out_eop` keep their values in the next cycle.
- R9: `err_trunc` and `err_stray` stay at 1 once set, and only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat buffer empty; beat accepted when both valid and ready |
| in_start | input | 1 | Beat contains a header |
| in_hdr_lane | input | 2 | Lane index of the header when `in_start` is 1 |
| in_len | input | 8 | Payload length in bytes minus one, for the header in this beat |
| in_data | input | 128 | Four 32-bit lanes, lane 0 in the low bits |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Word is a packet header |
| out_eop | output | 1 | Word ends a packet |
| err_trunc | output | 1 | Sticky: header arrived while a packet was still open |
| err_stray | output | 1 | Sticky: non-idle word found outside a packet |

## Verification
The assertions check several properties on every cycle. Output words hold steady under backpressure. A header word never carries end-of-packet. No packet remains open after an end-of-packet handshake. A truncation close is followed at once by the new header and raises the truncation flag. The error flags never fall. A newly accepted beat blocks the input. The directed scenarios alone can show which lanes are dropped and which are forwarded. They also show the payload word counts that follow from the length field, including at its extremes. Finally, they show packets spanning beats, a tail and a new header sharing one beat, and the exact cycle in which the input becomes ready again.

// File: rtl/unp_pkg.sv
package unp_pkg;

  // What the lane currently at the head of the beat buffer turns into.
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,  // buffer empty
    ACT_DROP  = 3'd1,  // lane outside any packet, discarded
    ACT_HDR   = 3'd2,  // header word, opens a packet
    ACT_PAY   = 3'd3,  // payload word of the open packet
    ACT_CLOSE = 3'd4   // inserted closing word for a truncated packet
  } lane_act_e;

  localparam logic [31:0] DEF_IDLE_WORD = 32'hC0DE_1D1E;

endpackage

// File: rtl/unp_beat_buf.sv
module unp_beat_buf #(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  parameter int LEN_W  = 8,
  localparam int LIDX_W = $clog2(LANES),
  localparam int BEAT_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_start,
  input  logic [LIDX_W-1:0] in_hdr_lane,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              lane_step,
  output logic              buf_full,
  output logic [LANE_W-1:0] cur_word,
  output logic              cur_is_hdr,
  output logic [LEN_W-1:0]  hdr_len
);

  localparam logic [LIDX_W-1:0] LAST_LANE = LIDX_W'(LANES - 1);

  logic [BEAT_W-1:0] data_q;
  logic              start_q;
  logic [LIDX_W-1:0] hdr_q;
  logic [LIDX_W-1:0] idx_q;
  logic              beat_accept;
  logic [LANE_W-1:0] lane_w [LANES];

  assign in_ready    = !buf_full;
  assign beat_accept = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_w[g] = data_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      idx_q    <= '0;
    end else if (beat_accept) begin
      buf_full <= 1'b1;
      idx_q    <= '0;
    end else if (lane_step) begin
      if (idx_q == LAST_LANE) buf_full <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_accept) begin
      data_q  <= in_data;
      start_q <= in_start;
      hdr_q   <= in_hdr_lane;
      hdr_len <= in_len;
    end
  end

  assign cur_word   = lane_w[idx_q];
  assign cur_is_hdr = buf_full && start_q && (idx_q == hdr_q);

  // R2: a freshly taken beat blocks the input on the following cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_accept |=> !in_ready);

endmodule

// File: rtl/unp_pkt_track.sv
module unp_pkt_track #(
  parameter int LANE_W = 32,
  parameter int LEN_W  = 8,
  localparam int BYTE_SHIFT = $clog2(LANE_W / 8),
  localparam int CNT_W      = LEN_W - BYTE_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hdr_fire,
  input  logic             pay_fire,
  input  logic             close_fire,
  input  logic [LEN_W-1:0] hdr_len,
  output logic             pkt_open,
  output logic             last_word
);

  logic [CNT_W-1:0] left_q;

  // Payload words for a length given as bytes minus one: ceil((len+1)/bytes_per_word).
  function automatic logic [CNT_W-1:0] words_for(input logic [LEN_W-1:0] len);
    return CNT_W'(len >> BYTE_SHIFT) + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_open <= 1'b0;
      left_q   <= '0;
    end else if (close_fire) begin
      pkt_open <= 1'b0;
      left_q   <= '0;
    end else if (hdr_fire) begin
      pkt_open <= 1'b1;
      left_q   <= words_for(hdr_len);
    end else if (pay_fire) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) pkt_open <= 1'b0;
    end
  end

  assign last_word = (left_q == CNT_W'(1));

  // R3: a packet that has just been opened owes at least one payload word
  assert_open_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |=> pkt_open && !last_word || pkt_open && last_word);

endmodule

// File: rtl/beat_unpacker.sv
module beat_unpacker #(
  parameter int          LANES     = 4,
  parameter int          LANE_W    = 32,
  parameter int          LEN_W     = 8,
  parameter logic [31:0] IDLE_WORD = unp_pkg::DEF_IDLE_WORD,
  localparam int LIDX_W = $clog2(LANES),
  localparam int BEAT_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_start,
  input  logic [LIDX_W-1:0] in_hdr_lane,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [BEAT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LANE_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              err_trunc,
  output logic              err_stray
);
  import unp_pkg::*;

  localparam logic [LANE_W-1:0] IDLE_LANE = LANE_W'(IDLE_WORD);

  logic              buf_full;
  logic [LANE_W-1:0] cur_word;
  logic              cur_is_hdr;
  logic [LEN_W-1:0]  hdr_len;
  logic              pkt_open;
  logic              last_word;
  lane_act_e         act;

  // Named internal events, also used by the assertions below.
  logic out_fire, hdr_fire, pay_fire, close_fire, lane_step, stray_seen;

  unp_beat_buf #(.LANES(LANES), .LANE_W(LANE_W), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_hdr_lane(in_hdr_lane), .in_len(in_len), .in_data(in_data),
    .lane_step(lane_step), .buf_full(buf_full), .cur_word(cur_word),
    .cur_is_hdr(cur_is_hdr), .hdr_len(hdr_len)
  );

  unp_pkt_track #(.LANE_W(LANE_W), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .hdr_fire(hdr_fire), .pay_fire(pay_fire), .close_fire(close_fire),
    .hdr_len(hdr_len), .pkt_open(pkt_open), .last_word(last_word)
  );

  // Lane classifier.
  always_comb begin
    act = ACT_NONE;
    if (buf_full) begin
      if (cur_is_hdr) act = pkt_open ? ACT_CLOSE : ACT_HDR;
      else            act = pkt_open ? ACT_PAY   : ACT_DROP;
    end
  end

  assign out_valid  = (act == ACT_HDR) || (act == ACT_PAY) || (act == ACT_CLOSE);
  assign out_data   = (act == ACT_CLOSE) ? IDLE_LANE : cur_word;
  assign out_sop    = (act == ACT_HDR);
  assign out_eop    = (act == ACT_CLOSE) || ((act == ACT_PAY) && last_word);

  assign out_fire   = out_valid && out_ready;
  assign hdr_fire   = out_fire && (act == ACT_HDR);
  assign pay_fire   = out_fire && (act == ACT_PAY);
  assign close_fire = out_fire && (act == ACT_CLOSE);
  assign lane_step  = (act == ACT_DROP) || hdr_fire || pay_fire;
  assign stray_seen = (act == ACT_DROP) && (cur_word != IDLE_LANE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_trunc <= 1'b0;
      err_stray <= 1'b0;
    end else begin
      if (close_fire) err_trunc <= 1'b1;
      if (stray_seen) err_stray <= 1'b1;
    end
  end

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

  assert_hdr_not_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !out_eop);

  assert_eop_closes_pkt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_eop |=> !pkt_open);

  assert_close_then_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    close_fire |=> out_valid && out_sop && err_trunc);

  assert_trunc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_trunc |=> err_trunc);

  assert_stray_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_stray |=> err_stray);

endmodule

// File: tb/beat_unpacker_tb.sv
`timescale 1ns/1ps
module beat_unpacker_tb;

  localparam logic [31:0] IDL = 32'hC0DE_1D1E;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_start = 1'b0;
  logic [1:0]   in_hdr_lane = '0;
  logic [7:0]   in_len = '0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_data;
  logic         out_sop, out_eop;
  logic         err_trunc, err_stray;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [33:0] got_q[$];
  logic [33:0] exp_q[$];

  always #10 clk = ~clk;

  beat_unpacker u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_hdr_lane(in_hdr_lane), .in_len(in_len), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .err_trunc(err_trunc), .err_stray(err_stray)
  );

  // Downstream ready pattern, changed just after each rising edge.
  always @(posedge clk) begin
    #2;
    out_ready = bp_on ? ((cyc % 3) != 1) : 1'b1;
    cyc++;
  end

  // Output collector, sampling mid-cycle.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) got_q.push_back({out_sop, out_eop, out_data});
  end

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic int words_of(input int len_m1);
    int bytes = len_m1 + 1;
    return (bytes + 3) / 4;
  endfunction

  task automatic expect_w(input bit sop, input bit eop, input logic [31:0] d);
    exp_q.push_back({sop, eop, d});
  endtask

  task automatic send_beat(input bit st, input logic [1:0] hl, input logic [7:0] ln,
                           input logic [31:0] w0, input logic [31:0] w1,
                           input logic [31:0] w2, input logic [31:0] w3);
    @(posedge clk); #2;
    in_valid = 1'b1; in_start = st; in_hdr_lane = hl; in_len = ln;
    in_data = {w3, w2, w1, w0};
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic compare_stream(input string req);
    int waited = 0;
    while (got_q.size() < exp_q.size() && waited < 3000) begin
      @(negedge clk); waited++;
    end
    repeat (12) @(negedge clk);
    check(got_q.size() == exp_q.size(), req,
          $sformatf("word count actual %0d expected %0d", got_q.size(), exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      check(got_q[i] === exp_q[i], req,
            $sformatf("word %0d actual sop/eop/data %b/%b/%h expected %b/%b/%h", i,
                      got_q[i][33], got_q[i][32], got_q[i][31:0],
                      exp_q[i][33], exp_q[i][32], exp_q[i][31:0]));
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1: reset values
  task automatic t_reset();
    do_reset();
    check(in_ready === 1'b1, "R1", $sformatf("in_ready actual %b expected 1", in_ready));
    check(out_valid === 1'b0, "R1", $sformatf("out_valid actual %b expected 0", out_valid));
    check(err_trunc === 1'b0 && err_stray === 1'b0, "R1",
          $sformatf("errors actual %b%b expected 00", err_trunc, err_stray));
  endtask

  // R2, R3: one short packet in one beat, lane order and ready timing
  task automatic t_single();
    int low_cnt = 0;
    bp_on = 1'b0;
    expect_w(1, 0, 32'hA000_0000 | 32'(7));
    expect_w(0, 0, 32'hA000_0001);
    expect_w(0, 1, 32'hA000_0002);
    send_beat(1, 2'd0, 8'd7, 32'hA000_0007, 32'hA000_0001, 32'hA000_0002, IDL);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (in_ready === 1'b0) low_cnt++;
    end
    check(low_cnt == 4, "R2", $sformatf("in_ready low cycles actual %0d expected 4", low_cnt));
    compare_stream("R3");
    check(err_trunc === 1'b0 && err_stray === 1'b0, "R4",
          $sformatf("errors after clean packet actual %b%b expected 00", err_trunc, err_stray));
  endtask

  // R5, R8: packet spanning three beats, idle value inside payload, backpressure
  task automatic t_span();
    bp_on = 1'b1;
    expect_w(1, 0, 32'hB000_001B);
    for (int i = 1; i <= 7; i++) begin
      logic [31:0] d = (i == 4) ? IDL : (32'hB000_0000 | 32'(i << 8));
      expect_w(0, (i == words_of(27)), d);
    end
    send_beat(1, 2'd1, 8'd27, IDL, 32'hB000_001B, 32'hB000_0100, 32'hB000_0200);
    send_beat(0, 2'd0, 8'd0, 32'hB000_0300, IDL, 32'hB000_0500, 32'hB000_0600);
    send_beat(0, 2'd0, 8'd0, 32'hB000_0700, IDL, IDL, IDL);
    compare_stream("R5");
    bp_on = 1'b0;
    check(err_stray === 1'b0, "R5", $sformatf("err_stray actual %b expected 0", err_stray));
  endtask

  // R6: tail of one packet, idle and a new header in the same beat; len 0 boundary
  task automatic t_mix();
    expect_w(1, 0, 32'hC000_0003);
    expect_w(0, 1, 32'hC000_0011);
    expect_w(1, 0, 32'hC000_0100);
    expect_w(0, 1, 32'hC000_0111);
    send_beat(1, 2'd3, 8'd3, IDL, IDL, IDL, 32'hC000_0003);
    send_beat(1, 2'd2, 8'd0, 32'hC000_0011, IDL, 32'hC000_0100, 32'hC000_0111);
    compare_stream("R6");
    check(err_trunc === 1'b0, "R6", $sformatf("err_trunc actual %b expected 0", err_trunc));
  endtask

  // R3: longest packet, 64 payload words across 17 beats
  task automatic t_max();
    logic [31:0] w[4];
    int n = 0;
    expect_w(1, 0, 32'hD000_00FF);
    for (int i = 1; i <= 64; i++) expect_w(0, (i == 64), 32'hD100_0000 | 32'(i));
    for (int b = 0; b < 17; b++) begin
      for (int l = 0; l < 4; l++) begin
        if (b == 0 && l == 0) w[l] = 32'hD000_00FF;
        else if (n < 64) begin n++; w[l] = 32'hD100_0000 | 32'(n); end
        else w[l] = IDL;
      end
      send_beat(b == 0, 2'd0, 8'd255, w[0], w[1], w[2], w[3]);
    end
    compare_stream("R3");
  endtask

  // R4: non-idle word outside a packet is dropped and flagged
  task automatic t_stray();
    send_beat(0, 2'd0, 8'd0, IDL, 32'h1234_5678, IDL, IDL);
    compare_stream("R4");
    check(err_stray === 1'b1, "R4", $sformatf("err_stray actual %b expected 1", err_stray));
    check(err_trunc === 1'b0, "R4", $sformatf("err_trunc actual %b expected 0", err_trunc));
  endtask

  // R7: header arrives while the previous packet still owes words
  task automatic t_trunc();
    expect_w(1, 0, 32'hE000_003F);
    for (int i = 1; i <= 4; i++) expect_w(0, 0, 32'hE000_0000 | 32'(i << 4));
    expect_w(0, 1, IDL);
    expect_w(1, 0, 32'hE100_0003);
    expect_w(0, 1, 32'hE100_0001);
    send_beat(1, 2'd0, 8'd63, 32'hE000_003F, 32'hE000_0010, 32'hE000_0020, 32'hE000_0030);
    send_beat(1, 2'd1, 8'd3, 32'hE000_0040, 32'hE100_0003, 32'hE100_0001, IDL);
    compare_stream("R7");
    check(err_trunc === 1'b1, "R7", $sformatf("err_trunc actual %b expected 1", err_trunc));
  endtask

  // R9: flags persist through clean traffic and clear only on reset
  task automatic t_sticky();
    expect_w(1, 0, 32'hF000_0000);
    expect_w(0, 1, 32'hF000_0001);
    send_beat(1, 2'd0, 8'd1, 32'hF000_0000, 32'hF000_0001, IDL, IDL);
    compare_stream("R9");
    check(err_trunc === 1'b1 && err_stray === 1'b1, "R9",
          $sformatf("flags actual %b%b expected 11", err_trunc, err_stray));
    do_reset();
    check(err_trunc === 1'b0 && err_stray === 1'b0, "R9",
          $sformatf("flags after reset actual %b%b expected 00", err_trunc, err_stray));
  endtask

  initial begin
    t_reset();
    t_single();
    t_span();
    t_mix();
    t_max();
    t_stray();
    t_trunc();
    t_sticky();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule